// File: doc/BRIEF.md
# Debug Breakpoint Match Unit

This block compares each cycle's instruction fetch address, data access and I/O port access against a set of hardware breakpoint slots. Each slot has an address register and a 4-bit configuration nibble (kind and watch length) taken from a packed control word. The control word also holds two enable bits per slot: a local one and a global one. When a slot fires, the block records which slots matched in a sticky hit-status field and raises a one-cycle debug-trap request. It also reports the instruction address at which execution should resume after the trap.

A single-step event sets a separate step-status bit and always requests the trap. I/O breakpoints are handled separately from code and data breakpoints. When an I/O slot fires, its hit mask replaces the hit-status field and the resume address becomes the next-instruction address supplied with the I/O access. Code and data checks work differently: they record every slot that matched, enabled or not, but only an enabled match, or a step, causes the status to be written.

All inputs pass through one register stage. The match logic sits between that stage and the status registers, so a stimulus presented before clock edge k appears on the outputs after edge k+1.

Top module: `dbg_bp_match`

## Requirements
- R1: Slot i is enabled when control bit 2i (local) or bit 2i+1 (global) is set. An enabled execute slot that matches requests the trap, and a disabled one does not.
- R2: The watch-length code in control bits [18+4i +: 2] maps 0 to 1 byte, 1 to 2 bytes, 2 to 8 bytes and 3 to 4 bytes.
- R3: The slot kind sits in control bits [16+4i +: 2], with 00 execute, 01 data write, 10 I/O, 11 data read/write. An execute slot matches when a valid fetch address equals its address register.
- R4: A data slot matches when the access bytes [addr, addr+2^size-1] overlap [base, base+len-1]. A write-only slot ignores reads, and a read/write slot matches both reads and writes.
- R5: An I/O slot fires only when it is enabled and the port bytes [port, port+2^size-1] overlap its watch range. Its hit mask replaces the hit-status field, and the resume address becomes the supplied next-instruction address.
- R6: When a code or data check updates the status, the hit-status field equals the set of all matching execute and data slots, enabled or not. The resume address equals the fetch address.
- R7: Without an I/O hit, an enabled code/data hit or a step, the hit-status field, the step bit and the resume address stay unchanged, and no trap is requested.
- R8: A step event sets the sticky step-status bit, requests the trap and writes the code/data match set into the hit-status field, even when no slot matched.
- R9: After reset all outputs are zero. The trap request is a one-cycle pulse on the second clock edge after the stimulus is presented.
- R10: An I/O hit takes priority over a code/data hit in the same cycle for the hit-status field and the resume address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bp_ctl | input | 16+4*NSLOT | Packed enables and per-slot kind/length nibbles |
| bp_addr | input | NSLOT*AW | Slot address registers, slot i at [i*AW +: AW] |
| fetch_valid | input | 1 | Fetch address valid |
| fetch_ip | input | AW | Current instruction address |
| dacc_valid | input | 1 | Data access valid |
| dacc_addr | input | AW | Data access start address |
| dacc_size | input | 2 | Log2 of data access bytes |
| dacc_write | input | 1 | Data access is a write |
| io_valid | input | 1 | I/O access valid |
| io_port | input | PW | I/O port number |
| io_size | input | 2 | Log2 of I/O access bytes |
| io_next_ip | input | AW | Address of the instruction after the I/O access |
| step_evt | input | 1 | Single-step event |
| trap_req | output | 1 | Debug-trap request pulse |
| hit_status | output | NSLOT | Sticky per-slot hit bits |
| step_status | output | 1 | Sticky single-step bit |
| resume_ip | output | AW | Resume address for the trap |

## Verification
The hardest case to reach from the ports is a status update in which disabled slots also set their bits. It needs an enabled slot and one or more disabled slots matching on the same fetch. The stimulus sets all four execute slots to one common address and enables only one of them. A second hard case is an I/O hit in the same cycle as an enabled execute hit, which is built by aiming an I/O slot and an execute slot at the same vector. Beyond these, full sweeps of offset, size and length around the edges of a watch range cover the overlap arithmetic, and a pseudo-random mixed phase checks the rest against an arithmetic model.

// File: rtl/dbg_bp_pkg.sv
package dbg_bp_pkg;
  typedef enum logic [1:0] {
    BPK_EXEC = 2'b00,
    BPK_WR   = 2'b01,
    BPK_IO   = 2'b10,
    BPK_RW   = 2'b11
  } bp_kind_e;

  localparam int CFG_BASE = 16;   // per-slot nibbles start here
  localparam int CFG_W    = 4;    // kind[1:0], len[3:2]

  // Watch length: non-linear code
  function automatic logic [3:0] watch_len(input logic [1:0] code);
    case (code)
      2'd0:    watch_len = 4'd1;
      2'd1:    watch_len = 4'd2;
      2'd2:    watch_len = 4'd8;
      default: watch_len = 4'd4;
    endcase
  endfunction

  // Access size from log2 code
  function automatic logic [3:0] acc_bytes(input logic [1:0] code);
    acc_bytes = 4'd1 << code;
  endfunction
endpackage

// File: rtl/dbg_bp_slot.sv
module dbg_bp_slot
  import dbg_bp_pkg::*;
#(
  parameter int AW = 32,
  parameter int PW = 16
) (
  input  logic [1:0]    en_bits,
  input  logic [3:0]    cfg,
  input  logic [AW-1:0] base,
  input  logic          fetch_v,
  input  logic [AW-1:0] fetch_a,
  input  logic          dat_v,
  input  logic [AW-1:0] dat_a,
  input  logic [1:0]    dat_sz,
  input  logic          dat_wr,
  input  logic          io_v,
  input  logic [PW-1:0] io_p,
  input  logic [1:0]    io_sz,
  output logic          slot_en,
  output logic          cd_hit,
  output logic          io_hit
);
  localparam int EW = AW + 1;   // one spare bit so range ends never wrap

  bp_kind_e      kind;
  logic [EW-1:0] w_lo, w_hi, d_lo, d_hi, p_lo, p_hi;
  logic          d_ovl, p_ovl;

  assign kind  = bp_kind_e'(cfg[1:0]);
  assign w_lo  = EW'(base);
  assign w_hi  = w_lo + EW'(watch_len(cfg[3:2])) - EW'(1);
  assign d_lo  = EW'(dat_a);
  assign d_hi  = d_lo + EW'(acc_bytes(dat_sz)) - EW'(1);
  assign p_lo  = EW'(io_p);
  assign p_hi  = p_lo + EW'(acc_bytes(io_sz)) - EW'(1);
  assign d_ovl = (d_lo <= w_hi) && (w_lo <= d_hi);
  assign p_ovl = (p_lo <= w_hi) && (w_lo <= p_hi);

  always_comb begin
    slot_en = |en_bits;
    cd_hit  = 1'b0;
    io_hit  = 1'b0;
    case (kind)
      BPK_EXEC: cd_hit = fetch_v && (fetch_a == base);
      BPK_WR:   cd_hit = dat_v && dat_wr && d_ovl;
      BPK_RW:   cd_hit = dat_v && d_ovl;
      BPK_IO:   io_hit = io_v && slot_en && p_ovl;
      default:  cd_hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/dbg_bp_status.sv
module dbg_bp_status #(
  parameter int NSLOT = 4,
  parameter int AW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSLOT-1:0] cd_mask,
  input  logic [NSLOT-1:0] en_mask,
  input  logic [NSLOT-1:0] io_mask,
  input  logic             step,
  input  logic [AW-1:0]    fetch_a,
  input  logic [AW-1:0]    io_next,
  output logic [NSLOT-1:0] hit_status,
  output logic             step_status,
  output logic             trap,
  output logic [AW-1:0]    resume_ip
);
  logic             io_any, en_hit, upd;
  logic [NSLOT-1:0] hit_nxt;
  logic [AW-1:0]    resume_nxt;
  logic             step_nxt;

  always_comb begin
    io_any     = |io_mask;
    en_hit     = |(cd_mask & en_mask);
    upd        = io_any | en_hit | step;
    hit_nxt    = io_any ? io_mask : cd_mask;
    resume_nxt = io_any ? io_next : fetch_a;
    step_nxt   = step_status | step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_status  <= '0;
      resume_ip   <= '0;
      step_status <= 1'b0;
      trap        <= 1'b0;
    end else begin
      trap        <= upd;
      step_status <= step_nxt;
      if (upd) begin
        hit_status <= hit_nxt;
        resume_ip  <= resume_nxt;
      end
    end
  end
endmodule

// File: rtl/dbg_bp_match.sv
module dbg_bp_match
  import dbg_bp_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int AW    = 32,
  parameter int PW    = 16,
  parameter int CW    = CFG_BASE + CFG_W * NSLOT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CW-1:0]       bp_ctl,
  input  logic [NSLOT*AW-1:0] bp_addr,
  input  logic                fetch_valid,
  input  logic [AW-1:0]       fetch_ip,
  input  logic                dacc_valid,
  input  logic [AW-1:0]       dacc_addr,
  input  logic [1:0]          dacc_size,
  input  logic                dacc_write,
  input  logic                io_valid,
  input  logic [PW-1:0]       io_port,
  input  logic [1:0]          io_size,
  input  logic [AW-1:0]       io_next_ip,
  input  logic                step_evt,
  output logic                trap_req,
  output logic [NSLOT-1:0]    hit_status,
  output logic                step_status,
  output logic [AW-1:0]       resume_ip
);
  // Input register stage
  logic [CW-1:0]       ctl_q;
  logic [NSLOT*AW-1:0] addr_q;
  logic                fetch_v_q, dat_v_q, io_v_q, step_q, dat_wr_q;
  logic [AW-1:0]       fetch_q, dat_a_q, io_next_q;
  logic [1:0]          dat_sz_q, io_sz_q;
  logic [PW-1:0]       io_p_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q     <= '0;
      addr_q    <= '0;
      fetch_v_q <= 1'b0;
      dat_v_q   <= 1'b0;
      io_v_q    <= 1'b0;
      step_q    <= 1'b0;
      fetch_q   <= '0;
      dat_a_q   <= '0;
      dat_sz_q  <= '0;
      dat_wr_q  <= 1'b0;
      io_p_q    <= '0;
      io_sz_q   <= '0;
      io_next_q <= '0;
    end else begin
      ctl_q     <= bp_ctl;
      addr_q    <= bp_addr;
      fetch_v_q <= fetch_valid;
      dat_v_q   <= dacc_valid;
      io_v_q    <= io_valid;
      step_q    <= step_evt;
      if (fetch_valid) fetch_q <= fetch_ip;
      if (dacc_valid) begin
        dat_a_q  <= dacc_addr;
        dat_sz_q <= dacc_size;
        dat_wr_q <= dacc_write;
      end
      if (io_valid) begin
        io_p_q    <= io_port;
        io_sz_q   <= io_size;
        io_next_q <= io_next_ip;
      end
    end
  end

  logic [NSLOT-1:0] en_mask, cd_mask, io_mask;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    dbg_bp_slot #(.AW(AW), .PW(PW)) u_slot (
      .en_bits (ctl_q[2*g +: 2]),
      .cfg     (ctl_q[CFG_BASE + CFG_W*g +: CFG_W]),
      .base    (addr_q[g*AW +: AW]),
      .fetch_v (fetch_v_q),
      .fetch_a (fetch_q),
      .dat_v   (dat_v_q),
      .dat_a   (dat_a_q),
      .dat_sz  (dat_sz_q),
      .dat_wr  (dat_wr_q),
      .io_v    (io_v_q),
      .io_p    (io_p_q),
      .io_sz   (io_sz_q),
      .slot_en (en_mask[g]),
      .cd_hit  (cd_mask[g]),
      .io_hit  (io_mask[g])
    );
  end

  dbg_bp_status #(.NSLOT(NSLOT), .AW(AW)) u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .cd_mask     (cd_mask),
    .en_mask     (en_mask),
    .io_mask     (io_mask),
    .step        (step_q),
    .fetch_a     (fetch_q),
    .io_next     (io_next_q),
    .hit_status  (hit_status),
    .step_status (step_status),
    .trap        (trap_req),
    .resume_ip   (resume_ip)
  );
endmodule

// File: rtl/dbg_bp_match_chk.sv
module dbg_bp_match_chk #(
  parameter int NSLOT = 4,
  parameter int AW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NSLOT-1:0] cd_mask,
  input logic [NSLOT-1:0] en_mask,
  input logic [NSLOT-1:0] io_mask,
  input logic             step_q,
  input logic [AW-1:0]    io_next_q,
  input logic             trap_req,
  input logic [NSLOT-1:0] hit_status,
  input logic             step_status,
  input logic [AW-1:0]    resume_ip
);
  assert_step_trap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step_q |=> (trap_req && step_status));

  assert_step_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step_status |=> step_status);

  assert_io_replace_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|io_mask) |=> (trap_req && hit_status == $past(io_mask)
                    && resume_ip == $past(io_next_q)));

  assert_cd_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|io_mask) && (|(cd_mask & en_mask))) |=> (trap_req && hit_status == $past(cd_mask)));

  assert_quiet_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|io_mask) && !(|(cd_mask & en_mask)) && !step_q)
      |=> (!trap_req && $stable(hit_status) && $stable(resume_ip)));
endmodule

bind dbg_bp_match dbg_bp_match_chk #(.NSLOT(NSLOT), .AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cd_mask     (cd_mask),
  .en_mask     (en_mask),
  .io_mask     (io_mask),
  .step_q      (step_q),
  .io_next_q   (io_next_q),
  .trap_req    (trap_req),
  .hit_status  (hit_status),
  .step_status (step_status),
  .resume_ip   (resume_ip)
);

// File: tb/dbg_bp_match_bench.sv
module dbg_bp_match_bench;
  localparam int NS = 4;
  localparam int AW = 32;
  localparam int PW = 16;
  localparam int CW = 16 + 4 * NS;

  logic          clk, rst_n;
  logic [CW-1:0] bp_ctl;
  logic [NS*AW-1:0] bp_addr;
  logic          fetch_valid, dacc_valid, dacc_write, io_valid, step_evt;
  logic [AW-1:0] fetch_ip, dacc_addr, io_next_ip;
  logic [1:0]    dacc_size, io_size;
  logic [PW-1:0] io_port;
  logic          trap_req, step_status;
  logic [NS-1:0] hit_status;
  logic [AW-1:0] resume_ip;

  int nvec, nfail;
  bit done;
  logic [NS-1:0] exp_hit;
  logic          exp_step;
  logic [AW-1:0] exp_res;

  dbg_bp_match #(.NSLOT(NS), .AW(AW), .PW(PW)) u_dbg_bp_match (
    .clk(clk), .rst_n(rst_n), .bp_ctl(bp_ctl), .bp_addr(bp_addr),
    .fetch_valid(fetch_valid), .fetch_ip(fetch_ip),
    .dacc_valid(dacc_valid), .dacc_addr(dacc_addr), .dacc_size(dacc_size),
    .dacc_write(dacc_write), .io_valid(io_valid), .io_port(io_port),
    .io_size(io_size), .io_next_ip(io_next_ip), .step_evt(step_evt),
    .trap_req(trap_req), .hit_status(hit_status), .step_status(step_status),
    .resume_ip(resume_ip));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic longint wlen(input logic [1:0] c);
    case (c)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 8;
      default: return 4;
    endcase
  endfunction

  function automatic bit ovl(input longint a, input longint an, input longint b, input longint bn);
    return (a <= b + bn - 1) && (b <= a + an - 1);
  endfunction

  function automatic logic [AW-1:0] slot_addr(input int i);
    return bp_addr[i*AW +: AW];
  endfunction

  // One vector: drive, model, then sample two edges later
  task automatic run_vec(input string req,
                         input bit fv, input logic [AW-1:0] fa,
                         input bit dv, input logic [AW-1:0] da, input logic [1:0] ds, input bit dw,
                         input bit iv, input logic [PW-1:0] ip, input logic [1:0] is,
                         input logic [AW-1:0] inx, input bit st);
    logic [NS-1:0] cd, io, en;
    bit etrap;
    cd = '0; io = '0; en = '0;
    for (int i = 0; i < NS; i++) begin
      logic [1:0] k;
      longint L, b;
      en[i] = bp_ctl[2*i] | bp_ctl[2*i+1];
      k = bp_ctl[16 + 4*i +: 2];
      L = wlen(bp_ctl[18 + 4*i +: 2]);
      b = longint'(slot_addr(i));
      case (k)
        2'b00: cd[i] = fv && (fa == slot_addr(i));
        2'b01: cd[i] = dv && dw && ovl(longint'(da), longint'(1) << ds, b, L);
        2'b11: cd[i] = dv && ovl(longint'(da), longint'(1) << ds, b, L);
        default: io[i] = iv && en[i] && ovl(longint'(ip), longint'(1) << is, b, L);
      endcase
    end
    etrap = 1'b0;
    if (io != '0) begin
      exp_hit = io; exp_res = inx; etrap = 1'b1;
    end else if (((cd & en) != '0) || st) begin
      exp_hit = cd; etrap = 1'b1;
      if (fv) exp_res = fa;
    end
    if (st) exp_step = 1'b1;
    @(negedge clk);
    fetch_valid = fv; fetch_ip = fa;
    dacc_valid = dv; dacc_addr = da; dacc_size = ds; dacc_write = dw;
    io_valid = iv; io_port = ip; io_size = is; io_next_ip = inx;
    step_evt = st;
    @(negedge clk);
    fetch_valid = 0; dacc_valid = 0; io_valid = 0; step_evt = 0;
    @(negedge clk);
    chk({req, " trap"}, trap_req, etrap);
    chk({req, " hit_status"}, hit_status, exp_hit);
    chk({req, " step_status"}, step_status, exp_step);
    if (etrap && (io != '0 || fv)) chk({req, " resume_ip"}, resume_ip, exp_res);
    @(negedge clk);
    chk("R9 trap pulse ends", trap_req, 0);
  endtask

  function automatic logic [CW-1:0] nib(input int s, input logic [1:0] k, input logic [1:0] l);
    logic [CW-1:0] v;
    v = '0;
    v[16 + 4*s +: 4] = {l, k};
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    nvec = 0; nfail = 0; done = 0;
    rst_n = 0; bp_ctl = '0; bp_addr = '0;
    fetch_valid = 0; fetch_ip = '0; dacc_valid = 0; dacc_addr = '0;
    dacc_size = '0; dacc_write = 0; io_valid = 0; io_port = '0;
    io_size = '0; io_next_ip = '0; step_evt = 0;
    exp_hit = '0; exp_step = 0; exp_res = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 reset trap", trap_req, 0);
    chk("R9 reset hit", hit_status, 0);
    chk("R9 reset step", step_status, 0);
    chk("R9 reset resume", resume_ip, 0);

    // R1/R3: execute slots, distinct addresses, each enable combination
    for (int i = 0; i < NS; i++) bp_addr[i*AW +: AW] = 32'h1000 + 32'h100 * i;
    for (int s = 0; s < NS; s++)
      for (int e = 0; e < 4; e++) begin
        bp_ctl = '0;
        bp_ctl[2*s +: 2] = 2'(e);
        run_vec("R1 R3 exec hit", 1, slot_addr(s), 0, '0, 0, 0, 0, '0, 0, '0, 0);
        run_vec("R3 exec miss", 1, slot_addr(s) + 1, 0, '0, 0, 0, 0, '0, 0, '0, 0);
      end
    // R6: all slots at one address, only one enabled
    for (int i = 0; i < NS; i++) bp_addr[i*AW +: AW] = 32'h4440;
    for (int s = 0; s < NS; s++) begin
      bp_ctl = '0;
      bp_ctl[2*s+1] = 1'b1;
      run_vec("R6 disabled slots recorded", 1, 32'h4440, 0, '0, 0, 0, 0, '0, 0, '0, 0);
    end

    // R2/R4: data slot sweep around edges of the watch range
    for (int i = 0; i < NS; i++) bp_addr[i*AW +: AW] = 32'h9000_0000;
    bp_addr[0 +: AW] = 32'h2000;
    for (int t = 0; t < 2; t++)
      for (int l = 0; l < 4; l++) begin
        bp_ctl = nib(0, t ? 2'b11 : 2'b01, 2'(l));
        bp_ctl[0] = 1'b1;
        for (int off = -9; off <= 9; off++)
          for (int ds = 0; ds < 4; ds++)
            for (int dw = 0; dw < 2; dw++)
              run_vec("R2 R4 data overlap", 0, '0, 1, 32'h2000 + off, 2'(ds), 1'(dw),
                      0, '0, 0, '0, 0);
      end

    // R2/R5: I/O slot sweep with enable variations
    bp_addr[AW +: AW] = 32'h60;
    for (int l = 0; l < 4; l++)
      for (int e = 0; e < 3; e++) begin
        bp_ctl = nib(1, 2'b10, 2'(l));
        bp_ctl[2 +: 2] = 2'(e);
        for (int off = -9; off <= 9; off++)
          for (int is = 0; is < 3; is++)
            run_vec("R2 R5 io overlap", 0, '0, 0, '0, 0, 0, 1, 16'h60 + 16'(off), 2'(is),
                    32'h5000 + off, 0);
      end

    // R8: step with no match, then R10: I/O and exec hit together
    bp_ctl = '0;
    bp_addr[0 +: AW] = 32'h3000;
    run_vec("R8 step no match", 1, 32'h3333, 0, '0, 0, 0, 0, '0, 0, '0, 1);
    run_vec("R7 quiet hold", 1, 32'h3334, 0, '0, 0, 0, 0, '0, 0, '0, 0);
    bp_ctl = nib(1, 2'b10, 2'd3);
    bp_ctl[1:0] = 2'b01; bp_ctl[3:2] = 2'b10;
    run_vec("R10 io over exec", 1, 32'h3000, 0, '0, 0, 0, 1, 16'h62, 0, 32'h7777, 0);
    run_vec("R10 io with step", 0, '0, 0, '0, 0, 0, 1, 16'h61, 1, 32'h7778, 1);

    // R6/R7: pseudo-random mixed traffic against the model
    lf = 32'h1234_5678;
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r1, r2, r3;
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5; r1 = lf;
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5; r2 = lf;
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5; r3 = lf;
      bp_ctl = {r1[31:16], r2[7:0] & r2[15:8], r2[23:16] & r2[31:24]};
      for (int i = 0; i < NS; i++) bp_addr[i*AW +: AW] = 32'h100 + 32'(r3[8*i +: 5]);
      run_vec("R6 R7 mixed", r3[0], 32'h100 + 32'(r1[4:0]), r3[1], 32'h100 + 32'(r1[9:5]),
              r1[11:10], r1[12], r3[2] & r3[3], 16'h100 + 16'(r2[4:0]), r2[6:5] % 2'd3,
              r3 ^ r1, r3[31:29] == 3'd0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule